// File: doc/BRIEF.md
# Soft-Edge Slow PWM Generator

This block drives one on/off output for a heavily loaded switch, such as a heater, at a low cycle rate. A hard switching edge on that kind of load can be heard as a click. Each turn-on and each turn-off edge is therefore spread over a short burst of fast PWM periods whose duty steps gradually up or down. Between the edges the output holds steady low or steady high, and the fast counter then runs from a divided tick so that one steady period is several times longer.

A 7-bit duty request is doubled and sampled once per slow cycle. A hold-off input keeps the output low. The duty request is a plain level that is read whenever the block needs it, so it carries no valid/ready handshake and never exerts back-pressure. The same holds for hold-off. The drive output is a registered level.

Top module: `soft_edge_pwm`

## Requirements
- R1: While reset is asserted and after its release, `drive_out` is low, the machine sits in the sample phase, and the slow counter is zero.
- R2: At the end of each sample period, the doubled request `{duty_req,0}` is captured. If `hold_off` is high or the request is zero, the machine stays in the sample phase and `drive_out` stays low.
- R3: The phases run in this order: sample, steady low, pre-rise hold, rise, post-rise hold, steady high, fall, post-fall hold, then sample again. Each hold lasts one fast period at a constant level: low before the rise, high after it, and low after the fall. `drive_out` follows the phase one clock later.
- R4: The rise lasts 2^RAMP_LOG2 fast periods. In rise step s (counting from 1), the output is high for the first s*2^(FAST_W-RAMP_LOG2) clocks of the period, then low. The last step is high for the whole period.
- R5: The fall lasts 2^RAMP_LOG2 fast periods and uses the inverted compare. In step s the output is low for the first s*2^(FAST_W-RAMP_LOG2) clocks, then high, so the last step is low for the whole period.
- R6: During the ramps and holds, the fast counter advances on every clock, so one period is 2^FAST_W clocks. During sample, steady low and steady high, it advances once every 2^DIV_LOG2 clocks. The divider restarts on entry to these phases, so each such period is exactly 2^(FAST_W+DIV_LOG2) clocks.
- R7: The slow counter is SLOW_W = DUTY_W+1 bits wide, wraps freely, and is cleared only by reset. It is incremented at the end of each steady-low or steady-high period. Steady low continues while the incremented count exceeds the captured value. Steady high ends once the incremented count reaches or exceeds it. With the bench sizes (16-clock fast period, 32-clock slow period, 4-bit slow counter) and an unchanged request, cycle duty c gives: first high run 32*c, later high runs 32+32*c, and low gap 80+32*(16-c).
- R8: At the point where steady high would end, if the live doubled request is at least 2^SLOW_W-3, the machine stays in steady high and skips the fall.
- R9: A request change made after the capture has no effect on the current cycle. It is used from the next sample capture onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_off | input | 1 | Keeps the machine in the sample phase with the output low |
| duty_req | input | DUTY_W | Requested slow duty, doubled on capture |
| drive_out | output | 1 | Registered drive level for the load switch |

## Verification
The assertions assume that `hold_off` and `duty_req` are ordinary synchronous levels. They do not assume these inputs stay fixed for a whole cycle: the full-on test depends on the block reading the live request, and the capture test depends on it ignoring a late change. The stimulus changes the inputs only at falling clock edges, either in reset or at known run boundaries. The run-length expectations therefore rest on a known slow-counter value at each capture. Nothing in the bench requires `hold_off` to stay away from a cycle that is already under way.

// File: rtl/sep_pkg.sv
package sep_pkg;
  typedef enum logic [2:0] {
    PH_SAMPLE,
    PH_LOW,
    PH_L2R,
    PH_RISE,
    PH_R2H,
    PH_HIGH,
    PH_FALL,
    PH_F2L
  } sep_phase_e;

  function automatic logic phase_is_fast(sep_phase_e ph);
    return !(ph == PH_SAMPLE || ph == PH_LOW || ph == PH_HIGH);
  endfunction
endpackage

// File: rtl/sep_tick_div.sv
module sep_tick_div #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_mode,
  output logic tick
);
  generate
    if (DIV_LOG2 == 0) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [DIV_LOG2-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n || fast_mode) div_q <= '0;
        else                     div_q <= div_q + DIV_LOG2'(1);
      end
      assign tick = fast_mode || (&div_q);
    end
  endgenerate
endmodule

// File: rtl/sep_fast_ctr.sv
module sep_fast_ctr #(
  parameter int FAST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [FAST_W-1:0] cnt,
  output logic              wrap
);
  logic [FAST_W-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + FAST_W'(1);
  end
  assign cnt  = cnt_q;
  assign wrap = tick && (&cnt_q);
endmodule

// File: rtl/sep_phase_fsm.sv
module sep_phase_fsm
  import sep_pkg::*;
#(
  parameter int DUTY_W    = 7,
  parameter int RAMP_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrap,
  input  logic                 hold_off,
  input  logic [DUTY_W-1:0]    duty_req,
  output sep_phase_e           phase,
  output logic [RAMP_LOG2-1:0] ramp_step
);
  localparam int SLOW_W   = DUTY_W + 1;
  localparam int FULL_THR = (1 << SLOW_W) - 3;

  sep_phase_e           phase_q;
  logic [SLOW_W-1:0]    slow_q, cap_q, slow_nxt, req_x2;
  logic [RAMP_LOG2-1:0] ramp_q;
  logic                 full_on;

  assign slow_nxt = slow_q + SLOW_W'(1);
  assign req_x2   = {duty_req, 1'b0};
  assign full_on  = req_x2 >= SLOW_W'(FULL_THR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_SAMPLE;
      slow_q  <= '0;
      cap_q   <= '0;
      ramp_q  <= '0;
    end else if (wrap) begin
      unique case (phase_q)
        PH_SAMPLE: begin
          if (!hold_off && req_x2 != '0) begin
            cap_q   <= req_x2;
            phase_q <= PH_LOW;
          end
        end
        PH_LOW: begin
          slow_q <= slow_nxt;
          if (slow_nxt <= cap_q) phase_q <= PH_L2R;
        end
        PH_L2R: begin
          ramp_q  <= '0;
          phase_q <= PH_RISE;
        end
        PH_RISE: begin
          if (&ramp_q) phase_q <= PH_R2H;
          else         ramp_q  <= ramp_q + RAMP_LOG2'(1);
        end
        PH_R2H: phase_q <= PH_HIGH;
        PH_HIGH: begin
          slow_q <= slow_nxt;
          if (slow_nxt >= cap_q && !full_on) begin
            ramp_q  <= '0;
            phase_q <= PH_FALL;
          end
        end
        PH_FALL: begin
          if (&ramp_q) phase_q <= PH_F2L;
          else         ramp_q  <= ramp_q + RAMP_LOG2'(1);
        end
        PH_F2L: phase_q <= PH_SAMPLE;
        default: phase_q <= PH_SAMPLE;
      endcase
    end
  end

  assign phase     = phase_q;
  assign ramp_step = ramp_q;
endmodule

// File: rtl/sep_out_stage.sv
module sep_out_stage
  import sep_pkg::*;
#(
  parameter int FAST_W    = 8,
  parameter int RAMP_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sep_phase_e           phase,
  input  logic [FAST_W-1:0]    cnt,
  input  logic [RAMP_LOG2-1:0] ramp_step,
  output logic                 drive
);
  localparam int SHIFT = FAST_W - RAMP_LOG2;

  logic [FAST_W:0] step_w, cmp;
  logic            below, drive_d;

  assign step_w = (FAST_W+1)'(ramp_step) + (FAST_W+1)'(1);
  assign cmp    = step_w << SHIFT;
  assign below  = {1'b0, cnt} < cmp;

  always_comb begin
    unique case (phase)
      PH_RISE:         drive_d = below;
      PH_FALL:         drive_d = !below;
      PH_HIGH, PH_R2H: drive_d = 1'b1;
      default:         drive_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drive <= 1'b0;
    else        drive <= drive_d;
  end
endmodule

// File: rtl/soft_edge_pwm.sv
module soft_edge_pwm
  import sep_pkg::*;
#(
  parameter int FAST_W    = 8,
  parameter int RAMP_LOG2 = 4,
  parameter int DIV_LOG2  = 3,
  parameter int DUTY_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_off,
  input  logic [DUTY_W-1:0] duty_req,
  output logic              drive_out
);
  sep_phase_e           phase_q;
  logic                 tick, fast_wrap;
  logic [FAST_W-1:0]    fast_cnt;
  logic [RAMP_LOG2-1:0] ramp_step;

  sep_tick_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk(clk), .rst_n(rst_n), .fast_mode(phase_is_fast(phase_q)), .tick(tick)
  );

  sep_fast_ctr #(.FAST_W(FAST_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(fast_cnt), .wrap(fast_wrap)
  );

  sep_phase_fsm #(.DUTY_W(DUTY_W), .RAMP_LOG2(RAMP_LOG2)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wrap(fast_wrap), .hold_off(hold_off),
    .duty_req(duty_req), .phase(phase_q), .ramp_step(ramp_step)
  );

  sep_out_stage #(.FAST_W(FAST_W), .RAMP_LOG2(RAMP_LOG2)) u_out (
    .clk(clk), .rst_n(rst_n), .phase(phase_q), .cnt(fast_cnt),
    .ramp_step(ramp_step), .drive(drive_out)
  );
endmodule

// File: rtl/sep_checker.sv
module sep_checker
  import sep_pkg::*;
#(
  parameter int FAST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_off,
  input logic              drive_out,
  input sep_phase_e        phase,
  input logic              fast_wrap,
  input logic [FAST_W-1:0] fast_cnt
);
  assert_pre_rise_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_L2R |=> !drive_out);
  assert_post_rise_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_R2H |=> drive_out);
  assert_post_fall_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_F2L |=> !drive_out);
  assert_phase_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_wrap |=> phase == $past(phase));
  assert_hold_to_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_wrap && phase == PH_L2R) |=> phase == PH_RISE);
  assert_hold_to_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_wrap && phase == PH_R2H) |=> phase == PH_HIGH);
  assert_hold_to_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_wrap && phase == PH_F2L) |=> phase == PH_SAMPLE);
  assert_sample_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SAMPLE |=> !drive_out);
  assert_hold_off_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_wrap && phase == PH_SAMPLE && hold_off) |=> phase == PH_SAMPLE);
  assert_fast_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_is_fast(phase) && !fast_wrap) |=> fast_cnt == $past(fast_cnt) + FAST_W'(1));
endmodule

bind soft_edge_pwm sep_checker #(.FAST_W(FAST_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hold_off(hold_off), .drive_out(drive_out),
  .phase(phase_q), .fast_wrap(fast_wrap), .fast_cnt(fast_cnt)
);

// File: tb/soft_edge_pwm_tb_top.sv
module soft_edge_pwm_tb_top;
  localparam int FW = 4, RL = 2, DL = 1, DW = 3;
  localparam int NV = 6;
  // duty, first long high, steady low gap, steady long high  (R7)
  localparam int VEC[NV][4] = '{
    '{1,  64, 528,  96},
    '{2, 128, 464, 160},
    '{3, 192, 400, 224},
    '{4, 256, 336, 288},
    '{5, 320, 272, 352},
    '{6, 384, 208, 416}
  };
  localparam int RAMP_RUNS[6] = '{4, 12, 8, 8, 12, 4};

  logic clk = 1'b0, rst_n = 1'b0, hold_off = 1'b0;
  logic [DW-1:0] duty_req = '0;
  logic drive_out;
  int n_tests = 0, n_fail = 0, cyc_cnt = 0;
  int runs[32];

  always #10 clk = ~clk;

  soft_edge_pwm #(.FAST_W(FW), .RAMP_LOG2(RL), .DIV_LOG2(DL), .DUTY_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hold_off(hold_off), .duty_req(duty_req),
    .drive_out(drive_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic get_run(output int len, input int limit);
    logic lvl;
    lvl = drive_out;
    len = 0;
    while (drive_out == lvl && len < limit) begin
      @(negedge clk);
      len++;
    end
  endtask

  task automatic wait_high(input int limit, output int waited);
    waited = 0;
    while (!drive_out && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic collect(input int first, input int last);
    for (int i = first; i <= last; i++) get_run(runs[i], 5000);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 190000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc_cnt);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    // R1: reset state
    duty_req = 3'd3;
    repeat (3) @(negedge clk);
    check("R1 out in reset", int'(drive_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 out after release", int'(drive_out), 0);

    // Vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      duty_req = DW'(VEC[v][0]);
      do_reset();
      wait_high(3000, w);
      collect(0, 27);
      check("R7 first long high", runs[6], VEC[v][1]);
      check("R7 R6 steady low gap", runs[13], VEC[v][2]);
      check("R7 R3 steady long high", runs[20], VEC[v][3]);
      for (int k = 0; k < 6; k++) begin
        check("R4 rise step run", runs[14+k], RAMP_RUNS[k]);
        check("R5 fall step run", runs[21+k], RAMP_RUNS[k]);
      end
    end

    // R2: zero request keeps output low
    duty_req = '0;
    do_reset();
    wait_high(3000, w);
    check("R2 zero duty stays low", w, 3000);

    // R2: hold_off keeps output low
    duty_req = 3'd3;
    hold_off = 1'b1;
    do_reset();
    wait_high(3000, w);
    check("R2 hold_off stays low", w, 3000);
    hold_off = 1'b0;
    wait_high(3000, w);
    check("R2 release starts rise", int'(drive_out), 1);

    // R9: late change ignored in current cycle, used on next capture
    duty_req = 3'd3;
    do_reset();
    wait_high(3000, w);
    collect(0, 13);
    duty_req = 3'd5;
    collect(14, 27);
    check("R9 long high keeps captured", runs[20], 224);
    check("R9 next gap uses new request", runs[27], 112);

    // R8: full-on skips fall while request at max
    duty_req = 3'd7;
    do_reset();
    wait_high(3000, w);
    collect(0, 5);
    get_run(runs[6], 4000);
    check("R8 full-on held high", runs[6], 4000);
    duty_req = 3'd2;
    get_run(runs[7], 5000);
    check("R8 fall after request drop", int'(drive_out), 0);
    get_run(runs[8], 5000);
    get_run(runs[9], 5000);
    check("R8 R5 first fall low", runs[8], 4);
    check("R8 R5 first fall high", runs[9], 12);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule